// File: doc/BRIEF.md
# Limit-Compare Timer with Stoppable User Counter

A register-mapped timer slice. In its default system personality it counts 500 ns ticks up to a programmable limit, wraps back to zero and raises a level interrupt together with a sticky flag. Software acknowledges the event by reading the limit register, which also restarts the count. The count occupies bits 30..9 of the count register, so bits 8..0 always read as zero and bit 31 carries the sticky flag.

Setting the mode bit turns the same slice into a free-running user counter, 54 tick bits wide by default. Software can freeze and resume it without losing its value and reads it as two words. This mode never interrupts. A slice built as the global system timer cannot leave system mode.

The bus is a plain synchronous strobe interface. Read data is registered and appears the cycle after the read strobe. The tick input is a one-cycle enable that pulses at 2 MHz.

Top module: `limit_timer`

## Requirements
- R1: After reset, word 0 reads 0 (limit), word 1 reads 0, word 3 reads 1 (stopped), word 4 reads 0 (system mode) and `irq` is low; reset also returns a switchable slice from user mode to system mode.
- R2: A limit write stores `wr_data[30:0]`, except that an all-zero 32-bit value stores 0x7FFFFFFF. A stored limit of 0 behaves as 0x7FFFFFFF.
- R3: In system mode each tick raises the count by one. Word 1 reads `{reached, count[21:0], 9'b0}`.
- R4: With terminal T = effective_limit[30:9] (T = 1 if that is 0), the tick that would make the count reach T or more sets the count to 0 and sets the reached flag and `irq`. Both stay set until acknowledged.
- R5: In system mode a read of word 0 returns the limit, clears `irq` and the reached flag, and zeroes the count. If a wrap happens in the same cycle, the reached flag and `irq` stay set.
- R6: A write to word 0 loads the limit and zeroes the count. A write to word 2 loads the limit and keeps the count. A tick in the same cycle as either write is dropped.
- R7: The word index is `addr[4:2]`. Words 5..7 read 0 and ignore writes. Writes to word 1 have no effect.
- R8: Word 4 bit 0 selects user mode (1) or system mode (0) and reads back. When `SWITCHABLE` is 0, mode writes are ignored and word 4 reads 0.
- R9: In user mode a write to word 3 sets the stopped flag from bit 0. While stopped, ticks do not change the counter, and clearing the flag resumes counting from the held value. Word 3 reads the flag. Word 3 writes in system mode are ignored.
- R10: In user mode word 0 reads the counter bits above the low `LO_TICKS` bits, zero-extended, and word 1 reads `{count[LO_TICKS-1:0], zeros}`. Reads have no side effects, `irq` stays low and the reached flag never sets.
- R11: A limit below 0x200 gives T = 1, so every system-mode tick wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 2 MHz count enable |
| addr | input | 5 | Byte address, word index in bits 4..2 |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt, system mode only |

## Verification
System counting is swept over a set of limits that give terminals from 1 to 15. Each tick is followed by a count read, so an off-by-one in the wrap compare or in the limit shift shows up as a wrong count on a specific tick. Collisions are driven on purpose: a tick together with an acknowledge, with a reload that keeps the count and with a reload that zeroes it, and a reload that shrinks the limit below the running count. These separate the priority rules from the normal path. User mode is driven through stop, resume and roll of the low word into the high word on a second instance with a narrow low field. A fixed-mode instance shows that mode writes are ignored.

// File: rtl/limit_timer.sv
module limit_timer #(
  parameter bit SWITCHABLE = 1'b1,
  parameter int LO_TICKS   = 23,
  parameter int HI_TICKS   = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic [4:0]  addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq
);
  localparam int UW = LO_TICKS + HI_TICKS;
  localparam int SW = 22;
  localparam logic [30:0] LIM_MAX = '1;

  logic [30:0]   limit_q;
  logic [UW-1:0] cnt_q;
  logic          reached_q, irq_q, stop_q, user_q;

  logic [2:0]    idx;
  logic [30:0]   lim_eff, wr_lim;
  logic [SW-1:0] term_raw, term;
  logic [UW-1:0] cnt_inc;
  logic          lim_wr, load_wr, sys_step, usr_step, wrap, ack;
  logic          unused_ok;

  assign idx      = addr[4:2];
  assign lim_eff  = (limit_q == '0) ? LIM_MAX : limit_q;
  assign term_raw = lim_eff[30:9];
  assign term     = (term_raw == '0) ? SW'(1) : term_raw;
  assign cnt_inc  = cnt_q + 1'b1;
  assign wr_lim   = (wr_data == '0) ? LIM_MAX : wr_data[30:0];

  assign lim_wr   = wr_en && (idx == 3'd0 || idx == 3'd2);
  assign load_wr  = wr_en && idx == 3'd0;
  assign sys_step = tick_en && !user_q && !lim_wr;
  assign usr_step = tick_en &&  user_q && !stop_q && !lim_wr;
  assign wrap     = sys_step && (cnt_inc >= {{(UW-SW){1'b0}}, term});
  assign ack      = rd_en && idx == 3'd0 && !user_q;

  assign irq       = irq_q && !user_q;
  assign unused_ok = ^addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q   <= '0;
      cnt_q     <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      stop_q    <= 1'b1;
      user_q    <= 1'b0;
    end else begin
      if (lim_wr) limit_q <= wr_lim;

      if (load_wr || ack || wrap) cnt_q <= '0;
      else if (sys_step || usr_step) cnt_q <= cnt_inc;

      if (wrap) begin
        reached_q <= 1'b1;
        irq_q     <= 1'b1;
      end else if (ack) begin
        reached_q <= 1'b0;
        irq_q     <= 1'b0;
      end

      if (wr_en && idx == 3'd3 && user_q) stop_q <= wr_data[0];
      if (SWITCHABLE && wr_en && idx == 3'd4) user_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (idx)
        3'd0: rd_data <= user_q ? 32'(cnt_q[UW-1:LO_TICKS]) : {1'b0, limit_q};
        3'd1: rd_data <= user_q ? {cnt_q[LO_TICKS-1:0], {(32-LO_TICKS){1'b0}}}
                                : {reached_q, cnt_q[SW-1:0], 9'b0};
        3'd3: rd_data <= {31'b0, stop_q};
        3'd4: rd_data <= {31'b0, user_q};
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

module limit_timer_chk #(
  parameter int UW = 54
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          rd_en,
  input logic          wr_en,
  input logic [4:0]    addr,
  input logic          irq,
  input logic          user_q,
  input logic          stop_q,
  input logic          reached_q,
  input logic [UW-1:0] cnt_q,
  input logic [21:0]   term
);
  logic [UW-1:0] term_w;
  assign term_w = {{(UW-22){1'b0}}, term};

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[4:2] == 3'd0 && !user_q && !tick_en && !wr_en) |=> (!irq && !reached_q)); // R5
  AST_LOAD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] == 3'd0) |=> (cnt_q == '0)); // R6
  AST_RELOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] == 3'd2 && !rd_en) |=> $stable(cnt_q)); // R6
  AST_SYS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !user_q && !wr_en && !rd_en && (cnt_q + 1'b1) < term_w) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_REACHED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reached_q && !(rd_en && addr[4:2] == 3'd0)) |=> reached_q); // R4
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en && !wr_en) |=> irq); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q && stop_q && !wr_en) |=> $stable(cnt_q)); // R9
  AST_USER_NO_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q && !reached_q && !wr_en) |=> !reached_q); // R10
endmodule

bind limit_timer limit_timer_chk #(.UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .irq(irq), .user_q(user_q), .stop_q(stop_q),
  .reached_q(reached_q), .cnt_q(cnt_q), .term(term)
);

// File: tb/limit_timer_bench.sv
module limit_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [4:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_main, rd_small, rd_glob;
  logic        irq_main, irq_small, irq_glob;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint mcnt;
  longint mlim;
  bit mreach, mirq, mstop, muser;

  always #10 clk = ~clk;

  limit_timer u_limit_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_main), .irq(irq_main));

  limit_timer #(.LO_TICKS(4), .HI_TICKS(27)) u_limit_timer_small (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_small), .irq(irq_small));

  limit_timer #(.SWITCHABLE(1'b0)) u_limit_timer_glob (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_glob), .irq(irq_glob));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint term_of();
    longint le, t;
    le = (mlim == 0) ? 64'h7FFFFFFF : mlim;
    t = le >> 9;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic logic [31:0] exp_rd(input int a, input int lo);
    case (a)
      0: return muser ? 32'((mcnt >> lo) & 64'h7FFFFFFF) : 32'(mlim);
      1: return muser ? 32'((mcnt & ((64'd1 << lo) - 1)) << (32 - lo))
                      : {mreach, 22'(mcnt), 9'b0};
      3: return {31'b0, mstop};
      4: return {31'b0, muser};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    mcnt = 0; mlim = 0; mreach = 0; mirq = 0; mstop = 1; muser = 0;
  endtask

  task automatic op(input bit tk, input bit rd, input bit wr, input int a,
                    input logic [31:0] d, input string req);
    logic [31:0] e_main, e_small;
    bit lw, ack, wrap;
    e_main  = exp_rd(a, 23);
    e_small = exp_rd(a, 4);
    @(negedge clk);
    tick_en = tk; rd_en = rd; wr_en = wr; addr = 5'(a << 2); wr_data = d;
    @(negedge clk);
    tick_en = 0; rd_en = 0; wr_en = 0;
    lw = wr && (a == 0 || a == 2);
    ack = rd && a == 0 && !muser;
    wrap = 0;
    if (tk && !lw) begin
      if (muser) begin
        if (!mstop) mcnt++;
      end else if (mcnt + 1 >= term_of()) begin
        wrap = 1; mcnt = 0;
      end else mcnt++;
    end
    if (ack) begin
      mcnt = 0; mreach = wrap; mirq = wrap;
    end else if (wrap) begin
      mreach = 1; mirq = 1;
    end
    if (wr) begin
      case (a)
        0: begin mlim = (d == 0) ? 64'h7FFFFFFF : longint'(d[30:0]); mcnt = 0; end
        2: mlim = (d == 0) ? 64'h7FFFFFFF : longint'(d[30:0]);
        3: if (muser) mstop = d[0];
        4: muser = d[0];
        default: ;
      endcase
    end
    if (rd) begin
      chk(rd_main, e_main, req);
      chk(rd_small, e_small, req);
      if (a == 4) chk(rd_glob, 32'd0, "R8 fixed slice mode");
    end
    chk({31'b0, irq_main}, {31'b0, mirq && !muser}, req);
    chk({31'b0, irq_small}, {31'b0, mirq && !muser}, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic sweep(input logic [31:0] lim, input string req);
    longint t;
    op(0, 0, 1, 0, lim, req);
    t = term_of();
    for (int n = 0; n < t + 3; n++) begin
      op(1, 0, 0, 0, 0, req);
      op(0, 1, 0, 1, 0, req);
    end
    op(0, 1, 0, 0, 0, "R5 acknowledge");
    op(0, 1, 0, 1, 0, "R5 count after ack");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset state
    op(0, 1, 0, 0, 0, "R1 limit");
    op(0, 1, 0, 1, 0, "R1 count");
    op(0, 1, 0, 3, 0, "R1 stopped");
    op(0, 1, 0, 4, 0, "R1 mode");
    // R2 limit masking
    op(0, 0, 1, 0, 32'h0, "R2");          op(0, 1, 0, 0, 0, "R2 zero");
    op(0, 0, 1, 0, 32'hFFFFFFFF, "R2");   op(0, 1, 0, 0, 0, "R2 mask");
    op(0, 0, 1, 0, 32'h80000000, "R2");   op(0, 1, 0, 0, 0, "R2 bit31 only");
    op(0, 0, 1, 2, 32'h00001234, "R2");   op(0, 1, 0, 0, 0, "R2 plain");
    // R3 and R4 sweep over terminals
    sweep(32'h0400, "R4 T=2");
    sweep(32'h0600, "R4 T=3");
    sweep(32'h0A00, "R3 T=5");
    sweep(32'h1000, "R3 T=8");
    sweep(32'h1FFF, "R4 T=15");
    // R11 small limits
    sweep(32'h01FF, "R11 T=1");
    sweep(32'h0100, "R11 T=1 low");
    // R5 ack collides with wrap
    op(0, 0, 1, 0, 32'h0400, "R5");
    op(1, 0, 0, 0, 0, "R5");
    op(1, 1, 0, 0, 0, "R5 ack with wrap");
    op(0, 1, 0, 1, 0, "R5 reached pending");
    op(0, 1, 0, 0, 0, "R5 late ack");
    // R6 reload semantics
    op(0, 0, 1, 0, 32'h1000, "R6");
    for (int i = 0; i < 3; i++) op(1, 0, 0, 0, 0, "R6");
    op(0, 0, 1, 2, 32'h2000, "R6 keep");  op(0, 1, 0, 1, 0, "R6 kept count");
    op(1, 0, 1, 2, 32'h2000, "R6 tick dropped"); op(0, 1, 0, 1, 0, "R6 dropped tick");
    op(1, 0, 1, 0, 32'h2000, "R6 zero");  op(0, 1, 0, 1, 0, "R6 zeroed");
    for (int i = 0; i < 4; i++) op(1, 0, 0, 0, 0, "R6");
    op(0, 0, 1, 2, 32'h0400, "R6 shrink"); op(1, 0, 0, 0, 0, "R6 shrink wrap");
    op(0, 1, 0, 1, 0, "R6 shrink read");
    op(0, 1, 0, 0, 0, "R6 ack");
    // R7 decode
    op(1, 0, 0, 0, 0, "R7");
    for (int a = 5; a < 8; a++) op(0, 0, 1, a, 32'hFFFFFFFF, "R7 ignored write");
    op(0, 0, 1, 1, 32'h12345678, "R7 word1 write");
    op(0, 1, 0, 1, 0, "R7 count intact");
    op(0, 1, 0, 0, 0, "R7 limit intact");
    op(0, 1, 0, 4, 0, "R7 mode intact");
    for (int a = 5; a < 8; a++) op(0, 1, 0, a, 0, "R7 reads zero");
    // R8 mode switch
    op(0, 0, 1, 4, 32'h1, "R8"); op(0, 1, 0, 4, 0, "R8 user");
    // R9 and R10 user mode
    op(0, 0, 1, 0, 32'h0400, "R10 low limit");
    op(0, 1, 0, 3, 0, "R9 stopped at start");
    for (int i = 0; i < 5; i++) op(1, 0, 0, 0, 0, "R9 frozen");
    op(0, 1, 0, 1, 0, "R9 frozen low");
    op(0, 0, 1, 3, 32'h0, "R9 run"); op(0, 1, 0, 3, 0, "R9 running");
    for (int i = 0; i < 20; i++) op(1, 0, 0, 0, 0, "R10 no irq");
    op(0, 1, 0, 1, 0, "R10 low word");
    op(0, 1, 0, 0, 0, "R10 high word");
    op(0, 0, 1, 3, 32'h1, "R9 stop");
    for (int i = 0; i < 4; i++) op(1, 0, 0, 0, 0, "R9 held");
    op(0, 1, 0, 1, 0, "R9 held low");
    op(0, 0, 1, 3, 32'h0, "R9 resume");
    for (int i = 0; i < 30; i++) op(1, 0, 0, 0, 0, "R10 roll");
    op(0, 1, 0, 0, 0, "R10 high after roll");
    op(0, 1, 0, 1, 0, "R10 low after roll");
    op(0, 1, 0, 4, 0, "R8 still user");
    // back to system; stop writes ignored there
    op(0, 0, 1, 4, 32'h0, "R8 back");
    op(0, 0, 1, 3, 32'h1, "R9 sys write");
    op(0, 1, 0, 3, 0, "R9 ignored in system");
    // R1 reset leaves user mode
    op(0, 0, 1, 4, 32'h1, "R1");
    do_reset();
    op(0, 1, 0, 4, 0, "R1 mode after reset");
    op(0, 1, 0, 3, 0, "R1 stopped after reset");
    op(0, 1, 0, 1, 0, "R1 count after reset");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule